// File: doc/BRIEF.md
# Scan-Chain Programming Command Controller

This block is a test-data register that sits behind a boundary-scan TAP. The TAP provides single-cycle capture, shift and update strobes together with the serial input. The block returns its serial output on `tdo_o`. The chain always contains a 16-bit command stage next to the serial input. A 1024-bit memory segment can be spliced in after the command stage or removed from the chain. This means the length of the chain and the meaning of its bits change while the chain is in use.

A small controller decodes the command stage on every update strobe and picks one of three modes:
- **Command only:** the memory segment is detached.
- **Armed:** the memory is attached and writable. Exactly one following update decides whether the shifted image is committed.
- **Verify:** the memory is attached read-only. The stored contents can be shifted out and are not disturbed.

The stored memory is an internal register array. It changes only on an update strobe that carries the write command while the controller is armed.

All strobes are synchronous to `clk_i`, and at most one of them is high in any cycle.

Top module: `scan_prog_ctrl`

## Requirements
- R1: After reset the state is 0 (command only), `attached_o` is 0, the command stage and the stored memory are all zero, and `tdo_o` is 0.
- R2: The command stage lies nearest the serial input. With the memory attached, a bit shifted in appears on `tdo_o` after exactly 1040 shift strobes, and the last 16 of the 1040 bits out of a freshly captured chain are the command stage.
- R3: Bits shift one per shift strobe, least significant first. The command word is the last 16 bits shifted before update, with the earliest of them as bit 0. When the memory is attached and 1040 bits are shifted after capture, the k-th bit shifted lands in memory bit k for k < 1024.
- R4: Command 16'hA5E1, decoded in state 0 or state 2, moves the controller to state 1 (armed, writable) and sets `attached_o`.
- R5: In state 1, the next update always returns the controller to state 0 and detaches the memory. If the word is 16'hC3D2, the shifted memory image is committed. Any other word is an abort that leaves the stored memory unchanged.
- R6: Command 16'h5A0F moves the controller from state 0 or state 2 to state 2 (verify, read-only, attached). In that state a capture loads the stored memory into the segment, and after k shifts `tdo_o` shows stored bit k. Shifting never alters the stored contents.
- R7: Command 16'h0000 in state 2 returns the controller to state 0 with `attached_o` low.
- R8: Outside state 1, a word that is not one of the commands above leaves the state unchanged. The same holds for 16'hC3D2.
- R9: With the memory detached, a capture clears the command stage. For the next 16 shifts `tdo_o` gives zeros, and after that it echoes the serial input delayed by 16 shifts.
- R10: The stored memory changes only on the commit update of R5. Capture, shift and partial shifts never change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| capture_i | input | 1 | Capture strobe from the TAP |
| shift_i | input | 1 | Shift strobe, one bit per cycle |
| update_i | input | 1 | Update strobe; decodes the command stage |
| tdi_i | input | 1 | Serial data in |
| tdo_o | output | 1 | Serial data out |
| state_o | output | 2 | Controller state: 0 command only, 1 armed, 2 verify |
| attached_o | output | 1 | Memory segment is in the chain |

## Verification
The echo pattern run with the memory detached separates two things: the initial capture-cleared zeros from the delayed copy of the input, and so it exposes a wrong command-stage length or a wrong bit order. Distinct pseudo-random images are written and read back through verify, and each read also pushes a single marker bit through the full chain. A wrong bit mapping, an off-by-one chain length or a corrupting read each show up as a different mismatch. Aborts are exercised with several words: an unknown word, a partial shift followed by update, and a valid command other than write. A later read-back shows whether any of them leaked into the stored contents. Undefined words and a write issued outside the armed state are sent in both the idle state and the verify state to show that the state holds.

// File: rtl/scan_prog_pkg.sv
package scan_prog_pkg;
  localparam int unsigned CMD_W = 16;

  typedef enum logic [1:0] {
    ST_CMD    = 2'd0,
    ST_ARMED  = 2'd1,
    ST_VERIFY = 2'd2
  } prog_state_e;

  localparam logic [CMD_W-1:0] CMD_EN_WR  = 16'hA5E1;
  localparam logic [CMD_W-1:0] CMD_WRITE  = 16'hC3D2;
  localparam logic [CMD_W-1:0] CMD_VERIFY = 16'h5A0F;
  localparam logic [CMD_W-1:0] CMD_IDLE   = 16'h0000;
endpackage

// File: rtl/scan_cmd_stage.sv
module scan_cmd_stage #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         capture_i,
  input  logic         shift_i,
  input  logic         tdi_i,
  output logic [W-1:0] word_o,
  output logic         out_o
);
  logic [W-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        sr_q <= '0;
    else if (capture_i) sr_q <= '0;
    else if (shift_i)   sr_q <= {tdi_i, sr_q[W-1:1]};
  end

  assign word_o = sr_q;
  assign out_o  = sr_q[0];
endmodule

// File: rtl/scan_mem_seg.sv
module scan_mem_seg #(
  parameter int unsigned W = 1024
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         capture_i,
  input  logic         shift_i,
  input  logic         attached_i,
  input  logic         commit_i,
  input  logic         din_i,
  output logic         dout_o,
  output logic [W-1:0] store_o
);
  logic [W-1:0] shadow_q;
  logic [W-1:0] store_q;

  // shadow is frozen while detached
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      shadow_q <= '0;
    else if (attached_i && capture_i) shadow_q <= store_q;
    else if (attached_i && shift_i)   shadow_q <= {din_i, shadow_q[W-1:1]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       store_q <= '0;
    else if (commit_i) store_q <= shadow_q;
  end

  assign dout_o  = shadow_q[0];
  assign store_o = store_q;
endmodule

// File: rtl/scan_prog_fsm.sv
module scan_prog_fsm
  import scan_prog_pkg::*;
#(
  parameter int unsigned W = CMD_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         update_i,
  input  logic [W-1:0] cmd_i,
  output prog_state_e  state_o,
  output logic         commit_o
);
  prog_state_e state_q, state_d;
  logic is_en, is_wr, is_vf, is_idle;

  assign is_en   = (cmd_i == CMD_EN_WR);
  assign is_wr   = (cmd_i == CMD_WRITE);
  assign is_vf   = (cmd_i == CMD_VERIFY);
  assign is_idle = (cmd_i == CMD_IDLE);

  always_comb begin
    state_d = state_q;
    if (update_i) begin
      unique case (state_q)
        ST_CMD: begin
          if (is_en)      state_d = ST_ARMED;
          else if (is_vf) state_d = ST_VERIFY;
        end
        ST_ARMED: state_d = ST_CMD;  // commit or abort, always detach
        ST_VERIFY: begin
          if (is_en)        state_d = ST_ARMED;
          else if (is_idle) state_d = ST_CMD;
        end
        default: state_d = ST_CMD;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_CMD;
    else         state_q <= state_d;
  end

  assign state_o  = state_q;
  assign commit_o = update_i && (state_q == ST_ARMED) && is_wr;
endmodule

// File: rtl/scan_prog_ctrl.sv
module scan_prog_ctrl
  import scan_prog_pkg::*;
#(
  parameter int unsigned CMD_BITS = CMD_W,
  parameter int unsigned MEM_W    = 1024
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       capture_i,
  input  logic       shift_i,
  input  logic       update_i,
  input  logic       tdi_i,
  output logic       tdo_o,
  output logic [1:0] state_o,
  output logic       attached_o
);
  logic [CMD_BITS-1:0] cmd_q;
  logic                cmd_out;
  logic                mem_out;
  logic [MEM_W-1:0]    store_q;
  logic                commit;
  logic                attached;
  prog_state_e         state_q;

  scan_cmd_stage #(.W(CMD_BITS)) u_cmd (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .capture_i (capture_i),
    .shift_i   (shift_i),
    .tdi_i     (tdi_i),
    .word_o    (cmd_q),
    .out_o     (cmd_out)
  );

  scan_prog_fsm #(.W(CMD_BITS)) u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .update_i (update_i),
    .cmd_i    (cmd_q),
    .state_o  (state_q),
    .commit_o (commit)
  );

  assign attached = (state_q != ST_CMD);

  scan_mem_seg #(.W(MEM_W)) u_mem (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .capture_i  (capture_i),
    .shift_i    (shift_i),
    .attached_i (attached),
    .commit_i   (commit),
    .din_i      (cmd_out),
    .dout_o     (mem_out),
    .store_o    (store_q)
  );

  assign tdo_o      = attached ? mem_out : cmd_out;
  assign state_o    = state_q;
  assign attached_o = attached;
endmodule

// File: rtl/scan_prog_ctrl_chk.sv
module scan_prog_ctrl_chk
  import scan_prog_pkg::*;
#(
  parameter int unsigned CMD_BITS = CMD_W,
  parameter int unsigned MEM_W    = 1024
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                update_i,
  input logic [CMD_BITS-1:0] cmd_q,
  input prog_state_e         state_q,
  input logic [MEM_W-1:0]    store_q
);
  logic known;
  assign known = (cmd_q == CMD_EN_WR) || (cmd_q == CMD_WRITE) ||
                 (cmd_q == CMD_VERIFY) || (cmd_q == CMD_IDLE);

  p_arm_entry_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ARMED && $past(state_q) != ST_ARMED) |->
      ($past(update_i) && $past(cmd_q) == CMD_EN_WR));

  p_armed_exit_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ARMED && update_i) |=> (state_q == ST_CMD));

  p_verify_keep_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_VERIFY) |=> $stable(store_q));

  p_unknown_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (update_i && state_q != ST_ARMED && !known) |=> $stable(state_q));

  p_store_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(update_i && state_q == ST_ARMED && cmd_q == CMD_WRITE) |=> $stable(store_q));
endmodule

bind scan_prog_ctrl scan_prog_ctrl_chk #(.CMD_BITS(CMD_BITS), .MEM_W(MEM_W)) i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .update_i (update_i),
  .cmd_q    (cmd_q),
  .state_q  (state_q),
  .store_q  (store_q)
);

// File: tb/test_scan_prog_ctrl.sv
module test_scan_prog_ctrl;
  localparam int MEM_W = 1024;
  localparam logic [15:0] C_EN = 16'hA5E1, C_WR = 16'hC3D2,
                          C_VF = 16'h5A0F, C_IDLE = 16'h0000;

  logic clk_i = 0, rst_ni = 0;
  logic capture_i = 0, shift_i = 0, update_i = 0, tdi_i = 0;
  logic tdo_o, attached_o;
  logic [1:0] state_o;
  int total = 0, bad = 0;
  logic [MEM_W-1:0] exp_mem = '0;

  always #2.5 clk_i = ~clk_i;

  scan_prog_ctrl i_scan_prog_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .capture_i(capture_i), .shift_i(shift_i),
    .update_i(update_i), .tdi_i(tdi_i), .tdo_o(tdo_o), .state_o(state_o),
    .attached_o(attached_o)
  );

  function automatic logic pat(int i, int seed);
    int v;
    v = (i * 29 + seed * 11) ^ (i >> 4) ^ (seed << 3);
    return v[1];
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive at negedge, return at next negedge with strobes low
  task automatic step(logic c, logic s, logic u, logic d);
    capture_i = c; shift_i = s; update_i = u; tdi_i = d;
    @(negedge clk_i);
    capture_i = 0; shift_i = 0; update_i = 0; tdi_i = 0;
  endtask

  task automatic send_cmd(logic [15:0] w);
    step(1, 0, 0, 0);
    for (int i = 0; i < 16; i++) step(0, 1, 0, w[i]);
    step(0, 0, 1, 0);
  endtask

  task automatic chk_state(int exp_st, logic exp_att, string req);
    chk(state_o == 2'(exp_st), req, state_o, exp_st);
    chk(attached_o == exp_att, req, attached_o, exp_att);
  endtask

  task automatic t_reset;
    chk_state(0, 0, "R1 state");
    chk(tdo_o == 1'b0, "R1 tdo", tdo_o, 0);
  endtask

  task automatic t_echo;
    logic [31:0] p = 32'h9C3A_61F5;
    int errs = 0;
    step(1, 0, 0, 0);
    for (int i = 0; i < 32; i++) begin
      logic e = (i < 16) ? 1'b0 : p[i-16];
      if (tdo_o !== e) errs++;
      step(0, 1, 0, p[i]);
    end
    chk(errs == 0, "R9 echo", errs, 0);
    chk_state(0, 0, "R9 state");
  endtask

  task automatic t_unknown(int st, logic att);
    send_cmd(16'h1234);
    chk_state(st, att, "R8 unknown");
    send_cmd(C_WR);
    chk_state(st, att, "R8 write outside armed");
  endtask

  // armed-state image shift; commits only if cmd == WRITE
  task automatic t_write(int seed, logic [15:0] cmd, string req);
    int errs = 0;
    step(1, 0, 0, 0);
    for (int i = 0; i < MEM_W; i++) begin
      if (tdo_o !== exp_mem[i]) errs++;
      step(0, 1, 0, pat(i, seed));
    end
    for (int i = 0; i < 16; i++) step(0, 1, 0, cmd[i]);
    step(0, 0, 1, 0);
    chk(errs == 0, "R6 armed capture preload", errs, 0);
    if (cmd == C_WR)
      for (int i = 0; i < MEM_W; i++) exp_mem[i] = pat(i, seed);
    chk_state(0, 0, req);
  endtask

  // read in verify: data, then chain-length marker
  task automatic t_read(string req);
    int errs = 0, tail = 0;
    logic mark;
    step(1, 0, 0, 0);
    for (int i = 0; i < MEM_W + 16; i++) begin
      if (i < MEM_W && tdo_o !== exp_mem[i]) errs++;
      if (i >= MEM_W && tdo_o !== 1'b0) tail++;
      step(0, 1, 0, (i == 0) ? 1'b1 : 1'b0);
    end
    mark = tdo_o;
    chk(errs == 0, req, errs, 0);
    chk(tail == 0, "R2 command stage tail", tail, 0);
    chk(mark == 1'b1, "R2 chain length 1040", mark, 1);
    chk_state(2, 1, "R6 still verify");
  endtask

  task automatic t_partial;
    send_cmd(C_EN);
    chk_state(1, 1, "R4 armed");
    step(1, 0, 0, 0);
    for (int i = 0; i < 300; i++) step(0, 1, 0, 1'b1);
    step(0, 0, 1, 0);
    chk_state(0, 0, "R10 partial abort");
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    bad++; total++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    t_reset();
    t_echo();
    t_unknown(0, 0);
    send_cmd(C_VF);
    chk_state(2, 1, "R6 verify entry");
    t_read("R1 R6 store zero after reset");
    send_cmd(C_EN);
    chk_state(1, 1, "R4 enable from verify");
    t_write(1, C_WR, "R5 commit detaches");
    send_cmd(C_VF);
    t_read("R3 R5 image after commit");
    t_read("R6 second read unchanged");
    t_unknown(2, 1);
    send_cmd(C_IDLE);
    chk_state(0, 0, "R7 idle detach");
    send_cmd(C_EN);
    chk_state(1, 1, "R4 enable from idle");
    t_write(2, 16'hBEEF, "R5 abort unknown");
    send_cmd(C_EN);
    t_write(3, C_VF, "R5 abort with verify word");
    t_partial();
    send_cmd(C_VF);
    t_read("R10 image kept after aborts");
    send_cmd(C_EN);
    t_write(4, C_WR, "R5 second commit");
    send_cmd(C_VF);
    t_read("R3 second image");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule